// File: doc/BRIEF.md
# Tagged Multi-Lane Integer ALU Array

This block is a bank of independent integer ALU lanes that work on tagged words. Each word is a value field in the low bits plus a small type tag in the top bits. Every lane holds three registers: a left operand, a right operand and an operator code. A requester reaches one lane per request by giving a lane index and a port select. It can write the left, right or operator register, or read any of them back. It can also read the lane's result.

Arithmetic runs only on the value field. The result always carries the left operand's tag unchanged, so tagged pointers and typed values pass through arithmetic with their type intact.

Most operators are combinational, and their result is returned in the same cycle as the request. Multiply, divide and modulo go to one iterative engine that all lanes share. The engine starts only when a lane holding one of those operators has its result read. The requester holds its request and waits on the ready signal until the engine finishes.

Top module: `tagged_alu_array`

## Requirements
- R1: After reset every lane's left and right operands read back as zero, and its operator reads back as 0 (NOP).
- R2: A write to the left or right port stores all 36 bits, and a later read of that port returns them unchanged. A write to the operator port stores only write data bits [3:0]. A read of the operator port returns that code zero-extended, with bits [35:4] at zero.
- R3: Every write request sees req_ready high in the cycle it is presented and takes effect at that clock edge.
- R4: Operator codes are NOP=0, ADD=1, SUB=2, MUL=3, DIV=4, MOD=5, EQL=6, SL=7, SR=8, SRA=9, NOT=10, AND=11, OR=12, XOR=13, GT=14, LT=15. ADD and SUB wrap modulo 2^32. NOT inverts A and ignores B.
- R5: For every operator, result bits [35:32] equal the left operand's bits [35:32], and only bits [31:0] are computed.
- R6: Shift operators use only B[4:0] as the shift distance. SL and SR fill with zeros. SRA copies A[31] into the vacated bits.
- R7: EQL, GT and LT yield exactly 0 or 1. GT and LT compare A and B as signed 32-bit integers.
- R8: A read of the left, right or operator port, or a result read of any operator other than MUL, DIV and MOD, has req_ready high in the cycle it is presented.
- R9: A result read of a lane holding MUL, DIV or MOD raises req_ready exactly 33 clock edges after the request is first presented. MUL returns the low 32 bits of the product. DIV and MOD treat both operands as unsigned.
- R10: A divisor of zero makes DIV return 0xFFFFFFFF and MOD return A, with no other effect.
- R11: Writing one lane never changes another lane's registers.
- R12: NOP yields a value field of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; held until req_ready |
| req_write | input | 1 | 1 = write, 0 = read |
| req_lane | input | 3 | Lane index |
| req_port | input | 2 | 0 left, 1 right, 2 operator, 3 result (result is read only) |
| req_wdata | input | 36 | Write data, tag in [35:32] |
| req_ready | output | 1 | Request completes in this cycle |
| rdata | output | 36 | Read data, valid while req_ready is high on a read |

## Verification
Writes are due at the next edge. Operand, operator and combinational result reads are due in the same cycle the request is presented. MUL, DIV and MOD results are due 33 edges after presentation. The bench drives each request just after a falling edge and samples 1 ns later. For every request it counts the edges until req_ready rises. It requires that count to be 0 for single-cycle accesses and exactly 33 for the shared engine, and it compares the returned word only in the sample where ready is high.

// File: rtl/tagalu_pkg.sv
package tagalu_pkg;

    typedef enum logic [3:0] {
        OP_NOP = 4'd0,
        OP_ADD = 4'd1,
        OP_SUB = 4'd2,
        OP_MUL = 4'd3,
        OP_DIV = 4'd4,
        OP_MOD = 4'd5,
        OP_EQL = 4'd6,
        OP_SL  = 4'd7,
        OP_SR  = 4'd8,
        OP_SRA = 4'd9,
        OP_NOT = 4'd10,
        OP_AND = 4'd11,
        OP_OR  = 4'd12,
        OP_XOR = 4'd13,
        OP_GT  = 4'd14,
        OP_LT  = 4'd15
    } alu_op_e;

    typedef enum logic [1:0] {
        PORT_LEFT   = 2'd0,
        PORT_RIGHT  = 2'd1,
        PORT_OP     = 2'd2,
        PORT_RESULT = 2'd3
    } lane_port_e;

    function automatic logic op_is_iterative(input alu_op_e op);
        return (op == OP_MUL) || (op == OP_DIV) || (op == OP_MOD);
    endfunction

endpackage

// File: rtl/alu_lane_regs.sv
module alu_lane_regs
    import tagalu_pkg::*;
#(
    parameter int VAL_W = 32,
    parameter int TAG_W = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     wr_en,
    input  lane_port_e               wr_port,
    input  logic [VAL_W+TAG_W-1:0]   wr_data,
    output logic [VAL_W+TAG_W-1:0]   a_q,
    output logic [VAL_W+TAG_W-1:0]   b_q,
    output alu_op_e                  op_q
);
    localparam int WORD_W = VAL_W + TAG_W;

    typedef struct packed {
        logic [WORD_W-1:0] a;
        logic [WORD_W-1:0] b;
        alu_op_e           op;
    } lane_state_t;

    lane_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            case (wr_port)
                PORT_LEFT:  st_d.a  = wr_data;
                PORT_RIGHT: st_d.b  = wr_data;
                PORT_OP:    st_d.op = alu_op_e'(wr_data[3:0]);
                default:    st_d    = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.a  <= '0;
            st_q.b  <= '0;
            st_q.op <= OP_NOP;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_q  = st_q.a;
    assign b_q  = st_q.b;
    assign op_q = st_q.op;

endmodule

// File: rtl/alu_comb_unit.sv
module alu_comb_unit
    import tagalu_pkg::*;
#(
    parameter int VAL_W = 32
) (
    input  logic [VAL_W-1:0] a_val,
    input  logic [VAL_W-1:0] b_val,
    input  alu_op_e          op,
    output logic [VAL_W-1:0] y_val
);
    localparam int SH_W = $clog2(VAL_W);

    logic [SH_W-1:0]         sh;
    logic signed [VAL_W-1:0] a_s;
    logic signed [VAL_W-1:0] b_s;

    assign sh  = b_val[SH_W-1:0];
    assign a_s = a_val;
    assign b_s = b_val;

    always_comb begin
        y_val = '0;
        case (op)
            OP_ADD: y_val = a_val + b_val;
            OP_SUB: y_val = a_val - b_val;
            OP_EQL: y_val = VAL_W'(a_val == b_val);
            OP_SL:  y_val = a_val << sh;
            OP_SR:  y_val = a_val >> sh;
            OP_SRA: y_val = a_s >>> sh;
            OP_NOT: y_val = ~a_val;
            OP_AND: y_val = a_val & b_val;
            OP_OR:  y_val = a_val | b_val;
            OP_XOR: y_val = a_val ^ b_val;
            OP_GT:  y_val = VAL_W'(a_s > b_s);
            OP_LT:  y_val = VAL_W'(a_s < b_s);
            default: y_val = '0;
        endcase
    end

endmodule

// File: rtl/mdu_engine.sv
module mdu_engine
    import tagalu_pkg::*;
#(
    parameter int VAL_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  alu_op_e          op,
    input  logic [VAL_W-1:0] a_val,
    input  logic [VAL_W-1:0] b_val,
    output logic             busy,
    output logic             done,
    output logic [VAL_W-1:0] result
);
    localparam int CNT_W = $clog2(VAL_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(VAL_W - 1);

    typedef enum logic [1:0] {E_IDLE, E_RUN, E_DONE} eng_state_e;

    typedef struct packed {
        eng_state_e       state;
        logic [CNT_W-1:0] cnt;
        alu_op_e          op;
        logic [VAL_W-1:0] acc;
        logic [VAL_W-1:0] x;
        logic [VAL_W-1:0] y;
    } eng_t;

    eng_t st_d, st_q;
    logic [VAL_W:0]   rem_sh;
    logic [VAL_W-1:0] x_sh;

    always_comb begin
        st_d   = st_q;
        rem_sh = {st_q.acc, st_q.x[VAL_W-1]};
        x_sh   = st_q.x << 1;
        case (st_q.state)
            E_IDLE: begin
                if (start) begin
                    st_d.state = E_RUN;
                    st_d.cnt   = '0;
                    st_d.op    = op;
                    st_d.acc   = '0;
                    st_d.x     = a_val;
                    st_d.y     = b_val;
                end
            end
            E_RUN: begin
                if (st_q.op == OP_MUL) begin
                    if (st_q.y[0]) begin
                        st_d.acc = st_q.acc + st_q.x;
                    end
                    st_d.x = st_q.x << 1;
                    st_d.y = st_q.y >> 1;
                end else begin
                    if (rem_sh >= {1'b0, st_q.y}) begin
                        st_d.acc = VAL_W'(rem_sh - {1'b0, st_q.y});
                        st_d.x   = x_sh | VAL_W'(1);
                    end else begin
                        st_d.acc = rem_sh[VAL_W-1:0];
                        st_d.x   = x_sh;
                    end
                end
                st_d.cnt = st_q.cnt + 1'b1;
                if (st_q.cnt == LAST) begin
                    st_d.state = E_DONE;
                end
            end
            E_DONE:  st_d.state = E_IDLE;
            default: st_d.state = E_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.state <= E_IDLE;
            st_q.cnt   <= '0;
            st_q.op    <= OP_NOP;
            st_q.acc   <= '0;
            st_q.x     <= '0;
            st_q.y     <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy   = (st_q.state == E_RUN);
    assign done   = (st_q.state == E_DONE);
    assign result = (st_q.op == OP_DIV) ? st_q.x : st_q.acc;

endmodule

// File: rtl/tagged_alu_array.sv
module tagged_alu_array
    import tagalu_pkg::*;
#(
    parameter int LANES = 8,
    parameter int VAL_W = 32,
    parameter int TAG_W = 4,
    localparam int LW     = (LANES > 1) ? $clog2(LANES) : 1,
    localparam int WORD_W = VAL_W + TAG_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [LW-1:0]     req_lane,
    input  logic [1:0]        req_port,
    input  logic [WORD_W-1:0] req_wdata,
    output logic              req_ready,
    output logic [WORD_W-1:0] rdata
);
    typedef struct packed {
        logic [LW-1:0] eng_lane;
    } top_state_t;

    top_state_t st_d, st_q;

    lane_port_e        port_sel;
    logic [WORD_W-1:0] lane_a  [LANES];
    logic [WORD_W-1:0] lane_b  [LANES];
    alu_op_e           lane_op [LANES];

    logic [WORD_W-1:0] sel_a;
    logic [WORD_W-1:0] sel_b;
    alu_op_e           sel_op;
    logic              lane_ok;
    logic              rd_result;
    logic              sel_iter;
    logic              eng_start;
    logic              eng_busy;
    logic              eng_done;
    logic [VAL_W-1:0]  eng_result;
    logic [VAL_W-1:0]  comb_y;

    assign port_sel = lane_port_e'(req_port);

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        logic wr_here;
        assign wr_here = req_valid && req_write && (req_lane == LW'(i));
        alu_lane_regs #(
            .VAL_W(VAL_W),
            .TAG_W(TAG_W)
        ) u_regs (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_here),
            .wr_port(port_sel),
            .wr_data(req_wdata),
            .a_q    (lane_a[i]),
            .b_q    (lane_b[i]),
            .op_q   (lane_op[i])
        );
    end

    always_comb begin
        lane_ok = 32'(req_lane) < LANES;
        sel_a   = '0;
        sel_b   = '0;
        sel_op  = OP_NOP;
        if (lane_ok) begin
            sel_a  = lane_a[req_lane];
            sel_b  = lane_b[req_lane];
            sel_op = lane_op[req_lane];
        end
    end

    alu_comb_unit #(
        .VAL_W(VAL_W)
    ) u_comb (
        .a_val(sel_a[VAL_W-1:0]),
        .b_val(sel_b[VAL_W-1:0]),
        .op   (sel_op),
        .y_val(comb_y)
    );

    assign rd_result = req_valid && !req_write && (port_sel == PORT_RESULT);
    assign sel_iter  = op_is_iterative(sel_op);
    assign eng_start = rd_result && sel_iter && !eng_busy && !eng_done;

    mdu_engine #(
        .VAL_W(VAL_W)
    ) u_mdu (
        .clk   (clk),
        .rst_n (rst_n),
        .start (eng_start),
        .op    (sel_op),
        .a_val (sel_a[VAL_W-1:0]),
        .b_val (sel_b[VAL_W-1:0]),
        .busy  (eng_busy),
        .done  (eng_done),
        .result(eng_result)
    );

    always_comb begin
        st_d = st_q;
        if (eng_start) begin
            st_d.eng_lane = req_lane;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.eng_lane <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        req_ready = 1'b0;
        rdata     = '0;
        if (req_valid) begin
            if (req_write) begin
                req_ready = 1'b1;
            end else begin
                case (port_sel)
                    PORT_LEFT: begin
                        req_ready = 1'b1;
                        rdata     = sel_a;
                    end
                    PORT_RIGHT: begin
                        req_ready = 1'b1;
                        rdata     = sel_b;
                    end
                    PORT_OP: begin
                        req_ready = 1'b1;
                        rdata     = WORD_W'(sel_op);
                    end
                    default: begin
                        if (sel_iter) begin
                            req_ready = eng_done && (st_q.eng_lane == req_lane);
                            rdata     = {sel_a[WORD_W-1:VAL_W], eng_result};
                        end else begin
                            req_ready = 1'b1;
                            rdata     = {sel_a[WORD_W-1:VAL_W], comb_y};
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/tagged_alu_checker.sv
module tagged_alu_checker
    import tagalu_pkg::*;
#(
    parameter int VAL_W = 32,
    parameter int TAG_W = 4,
    localparam int WORD_W = VAL_W + TAG_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [1:0]        req_port,
    input logic              req_ready,
    input logic [WORD_W-1:0] rdata,
    input logic [TAG_W-1:0]  sel_tag,
    input logic [3:0]        sel_op,
    input logic              eng_busy
);
    logic rd;
    logic iter;
    logic cmp_op;

    assign rd     = req_valid && !req_write;
    assign iter   = op_is_iterative(alu_op_e'(sel_op));
    assign cmp_op = (sel_op == 4'(OP_EQL)) || (sel_op == 4'(OP_GT)) || (sel_op == 4'(OP_LT));

    // R3: writes complete in the cycle they are presented
    p_write_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write) |-> req_ready);

    // R8: single-cycle reads never stall
    p_comb_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && ((req_port != 2'd3) || !iter)) |-> req_ready);

    // R5: result tag follows the left operand of the addressed lane
    p_tag_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (req_port == 2'd3) && req_ready) |-> (rdata[WORD_W-1:VAL_W] == sel_tag));

    // R9: no iterative result is returned while the engine still iterates
    p_engine_stall_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (req_port == 2'd3) && iter && eng_busy) |-> !req_ready);

    // R7: comparisons are boolean
    p_bool_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (req_port == 2'd3) && cmp_op) |-> (rdata[VAL_W-1:0] <= VAL_W'(1)));

    // R2: operator readback is zero-extended
    p_op_readback_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && (req_port == 2'd2)) |-> (rdata[WORD_W-1:4] == '0));

endmodule

bind tagged_alu_array tagged_alu_checker #(
    .VAL_W(VAL_W),
    .TAG_W(TAG_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_port (req_port),
    .req_ready(req_ready),
    .rdata    (rdata),
    .sel_tag  (sel_a[WORD_W-1:VAL_W]),
    .sel_op   (sel_op),
    .eng_busy (eng_busy)
);

// File: tb/sim_tagged_alu_array.sv
`timescale 1ns/1ps
module sim_tagged_alu_array;

    localparam int LANES = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [2:0]  req_lane = '0;
    logic [1:0]  req_port = '0;
    logic [35:0] req_wdata = '0;
    logic        req_ready;
    logic [35:0] rdata;

    int checks = 0;
    int fails = 0;
    int cycles = 0;
    bit finished = 1'b0;

    logic [35:0] m_a  [LANES];
    logic [35:0] m_b  [LANES];
    logic [3:0]  m_op [LANES];

    always #2.5 clk = ~clk;

    tagged_alu_array u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_lane (req_lane),
        .req_port (req_port),
        .req_wdata(req_wdata),
        .req_ready(req_ready),
        .rdata    (rdata)
    );

    task automatic check(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_val(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
        logic signed [31:0] sa;
        logic signed [31:0] sb;
        sa = a;
        sb = b;
        case (op)
            4'd1:  return a + b;
            4'd2:  return a - b;
            4'd3:  return a * b;
            4'd4:  return (b == 0) ? 32'hFFFF_FFFF : a / b;
            4'd5:  return (b == 0) ? a : a % b;
            4'd6:  return {31'd0, a == b};
            4'd7:  return a << b[4:0];
            4'd8:  return a >> b[4:0];
            4'd9:  return sa >>> b[4:0];
            4'd10: return ~a;
            4'd11: return a & b;
            4'd12: return a | b;
            4'd13: return a ^ b;
            4'd14: return {31'd0, sa > sb};
            4'd15: return {31'd0, sa < sb};
            default: return 32'd0;
        endcase
    endfunction

    task automatic do_write(input int lane, input int port, input logic [35:0] d);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b1;
        req_lane  = 3'(lane);
        req_port  = 2'(port);
        req_wdata = d;
        #1;
        check(req_ready === 1'b1, "R3 write ready", {35'd0, req_ready}, 36'd1);
        @(posedge clk);
        #0.5;
        req_valid = 1'b0;
        if (port == 0) m_a[lane] = d;
        else if (port == 1) m_b[lane] = d;
        else if (port == 2) m_op[lane] = d[3:0];
    endtask

    task automatic do_read(input int lane, input int port, output logic [35:0] d, output int lat);
        @(negedge clk);
        req_valid = 1'b1;
        req_write = 1'b0;
        req_lane  = 3'(lane);
        req_port  = 2'(port);
        lat = 0;
        #1;
        while (req_ready !== 1'b1 && lat < 100) begin
            @(negedge clk);
            #1;
            lat++;
        end
        d = rdata;
        @(posedge clk);
        #0.5;
        req_valid = 1'b0;
    endtask

    task automatic check_result(input int lane, input string tag);
        logic [35:0] d;
        logic [35:0] e;
        int lat;
        int elat;
        bit iter;
        iter = (m_op[lane] == 4'd3) || (m_op[lane] == 4'd4) || (m_op[lane] == 4'd5);
        elat = iter ? 33 : 0;
        e = {m_a[lane][35:32], exp_val(m_a[lane][31:0], m_b[lane][31:0], m_op[lane])};
        do_read(lane, 3, d, lat);
        check(d === e, tag, d, e);
        check(lat == elat, iter ? "R9 engine latency" : "R8 same-cycle result", 36'(lat), 36'(elat));
    endtask

    task automatic setup(input int lane, input logic [35:0] a, input logic [35:0] b, input logic [3:0] op);
        do_write(lane, 0, a);
        do_write(lane, 1, b);
        do_write(lane, 2, {32'd0, op});
    endtask

    initial begin
        while (!finished) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !finished) begin
                finished = 1'b1;
                fails++;
                checks++;
                $display("FAIL watchdog actual=%0d expected<150000", cycles);
                $display("%0d/%0d checks passed", checks - fails, checks);
                $finish;
            end
        end
    end

    initial begin
        logic [35:0] d;
        int lat;
        void'($urandom(32'd20240611));
        for (int i = 0; i < LANES; i++) begin
            m_a[i] = '0; m_b[i] = '0; m_op[i] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of all lanes
        for (int i = 0; i < LANES; i++) begin
            for (int p = 0; p < 3; p++) begin
                do_read(i, p, d, lat);
                check(d === 36'd0 && lat == 0, "R1 reset readback", d, 36'd0);
            end
        end

        // R12: NOP yields zero value with A's tag
        do_write(2, 0, 36'hA_1234_5678);
        check_result(2, "R12 NOP result");

        // R2: full-width operand readback and op truncation
        do_write(3, 0, 36'hF_DEAD_BEEF);
        do_read(3, 0, d, lat);
        check(d === 36'hF_DEAD_BEEF, "R2 left readback", d, 36'hF_DEAD_BEEF);
        do_write(3, 1, 36'h5_0000_0001);
        do_read(3, 1, d, lat);
        check(d === 36'h5_0000_0001, "R2 right readback", d, 36'h5_0000_0001);
        do_write(3, 2, 36'hF_FFFF_FFF3);
        do_read(3, 2, d, lat);
        check(d === 36'd3 && lat == 0, "R2 op readback", d, 36'd3);

        // R11: other lanes untouched by writes to lane 3
        do_read(4, 0, d, lat);
        check(d === 36'd0, "R11 lane isolation", d, 36'd0);
        do_read(2, 1, d, lat);
        check(d === 36'd0, "R11 lane isolation", d, 36'd0);

        // R6: shift distance from B[4:0] only
        setup(1, 36'h3_8000_00F0, 36'h0_FFFF_FFE4, 4'd9);
        check_result(1, "R6 SRA");
        setup(1, 36'h3_8000_00F0, 36'h0_FFFF_FFE4, 4'd8);
        check_result(1, "R6 SR");
        setup(1, 36'h3_8000_00F1, 36'h0_0000_0021, 4'd7);
        check_result(1, "R6 SL");

        // R7: signed comparisons
        setup(5, 36'h1_FFFF_FFFF, 36'h0_0000_0001, 4'd14);
        check_result(5, "R7 GT signed");
        setup(5, 36'h1_FFFF_FFFF, 36'h0_0000_0001, 4'd15);
        check_result(5, "R7 LT signed");
        setup(5, 36'h1_0000_0007, 36'h9_0000_0007, 4'd6);
        check_result(5, "R7 EQL ignores tag");

        // R4: wrap and NOT ignoring B
        setup(6, 36'h2_FFFF_FFFF, 36'h0_0000_0002, 4'd1);
        check_result(6, "R4 ADD wrap");
        setup(6, 36'h2_0000_0000, 36'h0_0000_0001, 4'd2);
        check_result(6, "R4 SUB wrap");
        setup(6, 36'h2_0F0F_0F0F, 36'h7_1234_5678, 4'd10);
        check_result(6, "R4 NOT");

        // R9/R10: engine cases
        setup(7, 36'hC_FFFF_FFFF, 36'h0_FFFF_FFFF, 4'd3);
        check_result(7, "R9 MUL low half");
        setup(7, 36'hC_FFFF_FFF0, 36'h0_0000_0007, 4'd4);
        check_result(7, "R9 DIV unsigned");
        setup(7, 36'hC_FFFF_FFF0, 36'h0_0000_0007, 4'd5);
        check_result(7, "R9 MOD unsigned");
        setup(0, 36'h4_0000_1234, 36'hE_0000_0000, 4'd4);
        check_result(0, "R10 DIV by zero");
        setup(0, 36'h4_0000_1234, 36'hE_0000_0000, 4'd5);
        check_result(0, "R10 MOD by zero");
        // back-to-back engine reads on different lanes
        check_result(7, "R9 back-to-back");

        // R5: random mix, tag and value checked on every result
        for (int n = 0; n < 250; n++) begin
            int lane;
            logic [35:0] a;
            logic [35:0] b;
            logic [3:0] op;
            lane = $urandom_range(0, LANES - 1);
            a = {4'($urandom), $urandom};
            b = {4'($urandom), $urandom};
            op = 4'($urandom);
            if ($urandom_range(0, 7) == 0) b[31:0] = 32'd0;
            if ($urandom_range(0, 3) == 0) b[31:0] = $urandom_range(0, 40);
            if ((op == 4'd3 || op == 4'd4 || op == 4'd5) && $urandom_range(0, 2) != 0) op = 4'd1;
            setup(lane, a, b, op);
            check_result(lane, "R5 random result");
            if ($urandom_range(0, 3) == 0) begin
                do_read(lane, 1, d, lat);
                check(d === m_b[lane], "R2 random readback", d, m_b[lane]);
            end
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule